// File: doc/BRIEF.md
# Dual Network Alternation Controller

This controller lets one radio node be a member of two personal area networks at the same time. It stores two complete network identities, called set 0 and set 1. Each identity holds a network identifier, a short device address, a long device address, a channel number and a coordinator flag. The controller chooses one identity as the active one and drives its fields to the frame address filter and to the frequency synthesizer. It also produces a one-cycle switch pulse whenever the active identity changes, so that the synthesizer can retune.

Software selects one of two switching modes. In timed mode, a programmable dwell counter moves the node between the two networks without any software action. A switch that falls due while the radio reports busy waits until the radio is idle. In software mode, the set named by a select bit in the control word becomes active. While the dual feature is disabled, set 0 stays active and the dwell counter is held at its reload value.

Configuration goes through a simple write port and a combinational read port. A read-only status word reports the state of the alternation.

Top module: `dual_net_ctrl`

## Requirements
- R1: Address 2 holds the long address of set 0 and address 4 holds the long address of set 1. Address 3 (set 0) and address 5 (set 1) hold the identity word: network identifier in bits [15:0], short address in bits [31:16], channel in bits [36:32] and coordinator flag in bit 48. One cycle after a write, the active-identity outputs show the fields of whichever set is active, and a read of any of these addresses returns what was written.
- R2: The channel output always equals the channel of the active set. A switch changes it in the same cycle as the active-set output.
- R3: Control word (address 0): bit 0 enables dual operation, bit 1 selects timed mode (1) or software mode (0), bit 2 is the software select. While bit 0 is clear, set 0 is active one cycle later and the dwell counter holds its reload value. After enabling timed mode, the first switch comes dwell+2 cycles after the write cycle.
- R4: In timed mode, with busy low, the active set toggles every dwell+1 cycles, where dwell is the value at address 1 (reset value 16). A dwell of 0 toggles it on every cycle.
- R5: A timed switch that falls due while radio_busy is high is held back. The set toggles in the cycle after the first cycle in which busy is low again, and the dwell counter reloads at that point.
- R6: In software mode with dual operation enabled, the active set equals the select bit, one cycle after the control write that carries it.
- R7: switch_pulse is high for exactly the cycles in which the active set differs from its value in the previous cycle. A write that leaves the set unchanged gives no pulse.
- R8: A read of address 6 returns the status word: bit 0 dual enabled, bit 1 active set, bit 2 timed switch currently held back by busy, bit 3 timed mode. All other bits read 0, and unused addresses read 0.
- R9: The coordinator output follows the coordinator flag of the active set, so each network can be coordinated independently.
- R10: Writes to address 6 or 7 change no register. After reset, everything reads 0 except the dwell value of 16, and set 0 is active with no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 64 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 64 | Combinational read data |
| radio_busy | input | 1 | Radio is mid-frame; timed switches wait |
| act_set | output | 1 | Index of the active set |
| switch_pulse | output | 1 | One-cycle pulse on every change of the active set |
| act_netid | output | 16 | Network identifier of the active set |
| act_short | output | 16 | Short address of the active set |
| act_long | output | 64 | Long address of the active set |
| act_chan | output | 5 | Channel of the active set |
| act_coord | output | 1 | Coordinator flag of the active set |

## Verification
A behavioural model is compared against every output and against the read port on each cycle, while the read address sweeps all eight locations. Timed mode runs with a dwell of 5 and with a dwell of 0, which separates an off-by-one reload error from a correct period. Busy is raised across an expiry and also between expiries, which shows whether a switch is held back or dropped and whether a busy level with no switch due has any effect. Software mode writes a changing select value and then the same select value again, which separates a pulse on a real change from a pulse on every write. Writes to the status address and disabling the controller mid-run exercise the fallback to set 0.

// File: rtl/dnc_pkg.sv
package dnc_pkg;
    localparam int AW    = 3;
    localparam int DW    = 64;
    localparam int ID_W  = 16;
    localparam int SA_W  = 16;
    localparam int LA_W  = 64;
    localparam int CH_W  = 5;
    localparam int NSETS = 2;

    // identity word field positions
    localparam int F_NETID = 0;
    localparam int F_SHORT = 16;
    localparam int F_CHAN  = 32;
    localparam int F_COORD = 48;

    localparam logic [AW-1:0] A_CTRL   = 3'd0;
    localparam logic [AW-1:0] A_DWELL  = 3'd1;
    localparam logic [AW-1:0] A_SETS   = 3'd2;  // set s: long at A_SETS+2s, word at +1
    localparam logic [AW-1:0] A_STATUS = 3'd6;

    typedef struct packed {
        logic [LA_W-1:0] long_a;
        logic [ID_W-1:0] netid;
        logic [SA_W-1:0] short_a;
        logic [CH_W-1:0] chan;
        logic            coord;
    } ident_t;

    typedef struct packed {
        logic sel;
        logic timed;
        logic en;
    } ctrl_t;
endpackage

// File: rtl/dnc_regbank.sv
module dnc_regbank
    import dnc_pkg::*;
#(
    parameter int TMR_W     = 16,
    parameter int DWELL_RST = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [DW-1:0]           wr_data,
    input  logic [AW-1:0]           rd_addr,
    output logic [DW-1:0]           rd_data,
    input  logic                    st_act,
    input  logic                    st_pending,
    output ctrl_t                   ctrl,
    output logic                    sel_next,
    output logic [TMR_W-1:0]        dwell,
    output ident_t [NSETS-1:0]      idents
);
    typedef struct packed {
        ctrl_t                  ctrl;
        logic [TMR_W-1:0]       dwell;
        ident_t [NSETS-1:0]     ids;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (wr_addr == A_CTRL)  r_d.ctrl  = wr_data[2:0];
            if (wr_addr == A_DWELL) r_d.dwell = wr_data[TMR_W-1:0];
            for (int s = 0; s < NSETS; s++) begin
                if (wr_addr == A_SETS + AW'(2*s))
                    r_d.ids[s].long_a = wr_data[LA_W-1:0];
                if (wr_addr == A_SETS + AW'(2*s+1)) begin
                    r_d.ids[s].netid   = wr_data[F_NETID +: ID_W];
                    r_d.ids[s].short_a = wr_data[F_SHORT +: SA_W];
                    r_d.ids[s].chan    = wr_data[F_CHAN  +: CH_W];
                    r_d.ids[s].coord   = wr_data[F_COORD];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q       <= '0;
            r_q.dwell <= TMR_W'(DWELL_RST);
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CTRL)   rd_data[2:0] = r_q.ctrl;
        if (rd_addr == A_DWELL)  rd_data[TMR_W-1:0] = r_q.dwell;
        if (rd_addr == A_STATUS) rd_data[3:0] = {r_q.ctrl.timed, st_pending, st_act, r_q.ctrl.en};
        for (int s = 0; s < NSETS; s++) begin
            if (rd_addr == A_SETS + AW'(2*s))
                rd_data = r_q.ids[s].long_a;
            if (rd_addr == A_SETS + AW'(2*s+1)) begin
                rd_data[F_NETID +: ID_W] = r_q.ids[s].netid;
                rd_data[F_SHORT +: SA_W] = r_q.ids[s].short_a;
                rd_data[F_CHAN  +: CH_W] = r_q.ids[s].chan;
                rd_data[F_COORD]         = r_q.ids[s].coord;
            end
        end
    end

    assign ctrl     = r_q.ctrl;
    assign dwell    = r_q.dwell;
    assign idents   = r_q.ids;
    assign sel_next = (wr_en && wr_addr == A_CTRL) ? wr_data[2] : r_q.ctrl.sel;

    AST_STATUS_RO: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr >= A_STATUS) |=> (r_q == $past(r_q))); // R10
endmodule

// File: rtl/dnc_sequencer.sv
module dnc_sequencer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             timed,
    input  logic             sel_next,
    input  logic [TMR_W-1:0] dwell,
    input  logic             busy,
    output logic             act,
    output logic             pulse,
    output logic             pending
);
    typedef struct packed {
        logic [TMR_W-1:0] cnt;
        logic             act;
        logic             pulse;
    } seq_t;

    seq_t s_d, s_q;
    logic due;

    assign due = en && timed && (s_q.cnt == '0);

    always_comb begin
        s_d = s_q;
        if (!en) begin
            s_d.act = 1'b0;
            s_d.cnt = dwell;
        end else if (!timed) begin
            s_d.act = sel_next;
            s_d.cnt = dwell;
        end else if (s_q.cnt == '0) begin
            if (!busy) begin
                s_d.act = ~s_q.act;
                s_d.cnt = dwell;
            end
        end else begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
        s_d.pulse = (s_d.act != s_q.act);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign act     = s_q.act;
    assign pulse   = s_q.pulse;
    assign pending = due && busy;

    AST_DISABLED_SET0: assert property (@(posedge clk) disable iff (rst)
        !en |=> !act); // R3
    AST_TIMED_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (due && !busy) |=> (act != $past(act))); // R4
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (due && busy) |=> (act == $past(act))); // R5
    AST_SW_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (en && !timed) |=> (act == $past(sel_next))); // R6
    AST_PULSE_EDGE: assert property (@(posedge clk) disable iff (rst)
        pulse == (act != $past(act))); // R7
endmodule

// File: rtl/dual_net_ctrl.sv
module dual_net_ctrl
    import dnc_pkg::*;
#(
    parameter int TMR_W     = 16,
    parameter int DWELL_RST = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    input  logic            radio_busy,
    output logic            act_set,
    output logic            switch_pulse,
    output logic [ID_W-1:0] act_netid,
    output logic [SA_W-1:0] act_short,
    output logic [LA_W-1:0] act_long,
    output logic [CH_W-1:0] act_chan,
    output logic            act_coord
);
    ctrl_t              ctrl;
    logic               sel_next;
    logic [TMR_W-1:0]   dwell;
    ident_t [NSETS-1:0] idents;
    logic               act, pending;
    ident_t             cur;

    dnc_regbank #(.TMR_W(TMR_W), .DWELL_RST(DWELL_RST)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .st_act(act), .st_pending(pending),
        .ctrl(ctrl), .sel_next(sel_next), .dwell(dwell), .idents(idents)
    );

    dnc_sequencer #(.TMR_W(TMR_W)) u_seq (
        .clk(clk), .rst(rst), .en(ctrl.en), .timed(ctrl.timed), .sel_next(sel_next),
        .dwell(dwell), .busy(radio_busy), .act(act), .pulse(switch_pulse), .pending(pending)
    );

    assign cur          = idents[act];
    assign act_set      = act;
    assign act_netid    = cur.netid;
    assign act_short    = cur.short_a;
    assign act_long     = cur.long_a;
    assign act_chan     = cur.chan;
    assign act_coord    = cur.coord;

    AST_CHAN_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (act_chan != $past(act_chan)) |-> (switch_pulse || $past(wr_en))); // R2
endmodule

// File: tb/dual_net_ctrl_test.sv
module dual_net_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [63:0] rd_data;
    logic        radio_busy = 1'b0;
    logic        act_set, switch_pulse, act_coord;
    logic [15:0] act_netid, act_short;
    logic [63:0] act_long;
    logic [4:0]  act_chan;

    always #4 clk = ~clk;

    dual_net_ctrl uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .radio_busy(radio_busy),
        .act_set(act_set), .switch_pulse(switch_pulse), .act_netid(act_netid),
        .act_short(act_short), .act_long(act_long), .act_chan(act_chan), .act_coord(act_coord)
    );

    int vectors = 0, errors = 0;
    string act_req = "R10";

    // behavioural model
    bit m_en, m_timed, m_sel, m_act, m_pulse;
    int m_dwell, m_cnt;
    longint unsigned m_long [2];
    int m_netid [2], m_short [2], m_chan [2];
    bit m_coord [2];

    function automatic longint unsigned m_read(int a);
        longint unsigned v = 0;
        case (a)
            0: v = {m_sel, m_timed, m_en};
            1: v = m_dwell;
            2, 4: v = m_long[(a-2)/2];
            3, 5: v = (longint'(m_coord[(a-3)/2]) << 48) | (longint'(m_chan[(a-3)/2]) << 32)
                     | (longint'(m_short[(a-3)/2]) << 16) | longint'(m_netid[(a-3)/2]);
            6: v = {m_timed, (m_en && m_timed && m_cnt == 0 && radio_busy), m_act, m_en};
            default: v = 0;
        endcase
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_timed = 0; m_sel = 0; m_act = 0; m_pulse = 0;
            m_dwell = 16; m_cnt = 0;
            for (int s = 0; s < 2; s++) begin
                m_long[s] = 0; m_netid[s] = 0; m_short[s] = 0; m_chan[s] = 0; m_coord[s] = 0;
            end
        end else begin
            bit sel_now, nact;
            int ncnt;
            sel_now = (wr_en && wr_addr == 0) ? wr_data[2] : m_sel;
            nact = m_act; ncnt = m_cnt;
            if (!m_en) begin nact = 0; ncnt = m_dwell; end
            else if (!m_timed) begin nact = sel_now; ncnt = m_dwell; end
            else if (m_cnt == 0) begin
                if (!radio_busy) begin nact = !m_act; ncnt = m_dwell; end
            end else ncnt = m_cnt - 1;
            m_pulse = (nact != m_act);
            m_act = nact; m_cnt = ncnt;
            if (wr_en) begin
                case (wr_addr)
                    0: {m_sel, m_timed, m_en} = wr_data[2:0];
                    1: m_dwell = int'(wr_data[15:0]);
                    2, 4: m_long[(wr_addr-2)/2] = wr_data;
                    3, 5: begin
                        m_netid[(wr_addr-3)/2] = int'(wr_data[15:0]);
                        m_short[(wr_addr-3)/2] = int'(wr_data[31:16]);
                        m_chan[(wr_addr-3)/2]  = int'(wr_data[36:32]);
                        m_coord[(wr_addr-3)/2] = wr_data[48];
                    end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string req, string what, longint unsigned act_v, longint unsigned exp_v);
        vectors++;
        if (act_v != exp_v) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act_v, exp_v, $time);
        end
    endtask

    // compare 2 ns after each edge
    always @(posedge clk) begin
        #2;
        if (!rst) begin
            chk(act_req, "act_set", act_set, m_act);
            chk("R7", "switch_pulse", switch_pulse, m_pulse);
            chk("R2", "act_chan", act_chan, m_chan[m_act]);
            chk("R1", "act_netid", act_netid, m_netid[m_act]);
            chk("R1", "act_short", act_short, m_short[m_act]);
            chk("R1", "act_long", act_long, m_long[m_act]);
            chk("R9", "act_coord", act_coord, m_coord[m_act]);
            chk(rd_addr == 6 ? "R8" : "R10", "rd_data", rd_data, m_read(rd_addr));
        end
    end

    // sweep read address across all locations
    always @(negedge clk) rd_addr <= rd_addr + 3'd1;

    task automatic wr(int a, longint unsigned d);
        @(negedge clk);
        wr_en = 1; wr_addr = 3'(a); wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        act_req = "R10";
        idle(10);
        // R1 R9: load both identities
        act_req = "R1";
        wr(2, 64'h0011_2233_4455_6677);
        wr(3, (64'd1 << 48) * 0 | (64'd11 << 32) | (64'h1234 << 16) | 64'hABCD);
        wr(4, 64'h8899_AABB_CCDD_EEFF);
        wr(5, (64'd1 << 48) | (64'd20 << 32) | (64'h5678 << 16) | 64'h0F0F);
        wr(1, 5);
        idle(8);
        // R4: timed mode, dwell 5
        act_req = "R4";
        wr(0, 3'b011);
        idle(30);
        // R5: busy across expiries
        act_req = "R5";
        radio_busy = 1; idle(13);
        radio_busy = 0; idle(4);
        radio_busy = 1; idle(2);
        radio_busy = 0; idle(12);
        // R10: status writes ignored
        act_req = "R10";
        wr(6, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(7, 64'hFFFF_FFFF_FFFF_FFFF);
        idle(8);
        // R6: software mode
        act_req = "R6";
        wr(0, 3'b101); idle(5);
        wr(0, 3'b001); idle(5);
        wr(0, 3'b001); idle(3);
        wr(0, 3'b101); idle(2);
        wr(0, 3'b101); idle(6);
        // R1: rewrite the active identity while active
        wr(5, (64'd0 << 48) | (64'd26 << 32) | (64'h2222 << 16) | 64'h3333);
        idle(4);
        // R3: disable falls back to set 0
        act_req = "R3";
        wr(0, 3'b100); idle(20);
        // R4: dwell 0 toggles every cycle
        act_req = "R4";
        wr(1, 0);
        wr(0, 3'b011); idle(16);
        act_req = "R5";
        radio_busy = 1; idle(6);
        radio_busy = 0; idle(6);
        act_req = "R3";
        wr(0, 3'b000); idle(10);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule